// File: doc/BRIEF.md
# Wrapping Byte-Serial Load/Store Unit

This block carries out one scalar memory operation at a time against a 4 KiB byte-addressed data memory held in big-endian order. A request carries an operation code, the low address bits of a base register, the low address bits of an already sign-extended offset, the store data and the destination register index. The unit forms the effective address and walks the covered bytes one per cycle over a byte-wide memory port. Each step takes the next address, and the address rolls from 0xFFF back to 0x000. This lets halfword and word accesses start at any byte: they may split across two words, or straddle the top and bottom of memory, and need no special path.

Loads gather the returned bytes most significant first. They then zero- or sign-extend the value and present it on a result stream. A load whose destination is register 0 always presents zero. Stores drive only the bytes they cover, taking them from the low end of the store data. A one-cycle `done` strobe marks the end of every operation.

The request stream and the result stream both use valid/ready. The unit takes a request only while idle (`req_ready` high). `req_valid` and the request fields must stay steady until the request is accepted. Once `res_valid` rises, the result stays frozen until `res_ready` is sampled high. No new request is taken until that result has been consumed.

Top module: `lsu_wrap_unit`

## Requirements
- R1: The effective address is (req_base + req_offset) mod 4096. Both inputs are the low 12 bits of their full values, so a negative offset such as -16 arrives as 0xFF0. The first memory access of an operation uses this address.
- R2: Operation codes on req_op are 0 = signed byte load, 1 = unsigned byte load, 2 = signed halfword load, 3 = unsigned halfword load, 4 = word load, 5 = byte store, 6 = halfword store, 7 = word store. Byte operations make 1 access, halfword operations 2, word operations 4. There is one access per cycle on consecutive addresses, wrapping from 0xFFF to 0x000.
- R3: req_ready is high only while no operation is in progress. A request is accepted on a rising edge with req_valid and req_ready both high. The first access (mem_en high) occurs in the next cycle, and mem_en is never high while req_ready is high.
- R4: A store drives mem_we only on its own 1, 2 or 4 accesses. Access k carries byte k counted from the most significant byte of the low 8, 16 or 32 bits of req_wdata. Higher bits of req_wdata have no effect, and no other memory byte is written.
- R5: mem_rdata must hold the addressed byte in the cycle after a read access. For a load of n bytes, res_valid rises n+2 cycles after acceptance and is low in the cycle before. No access happens while res_valid is high.
- R6: A signed byte load sign-extends bit 7 of the byte to 32 bits. An unsigned byte load zero-extends it.
- R7: A halfword load puts the lower-addressed byte in bits 15:8. The signed form sign-extends from bit 15 and the unsigned form zero-extends. A start address with low bits 3 (including 0xFFF) splits the access across words or across the memory wrap.
- R8: A word load or store at any byte address accesses four consecutive wrapped bytes, with the lowest address holding bits 31:24.
- R9: A load whose req_rd is 0 presents res_data = 0, whatever memory holds.
- R10: While res_valid is high and res_ready is low, res_valid, res_data and res_rd stay unchanged.
- R11: done is high for exactly one cycle per operation. For a store this is the cycle after its last access. For a load it is the cycle after the edge on which the result is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_op | input | 3 | Operation code (see R2) |
| req_base | input | 12 | Low address bits of the base register |
| req_offset | input | 12 | Low address bits of the sign-extended offset |
| req_wdata | input | 32 | Store source register value |
| req_rd | input | 5 | Destination register index for loads |
| mem_en | output | 1 | Byte access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 12 | Byte address of the access |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after a read access |
| res_valid | output | 1 | Load result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Extended load value |
| res_rd | output | 5 | Destination register of the result |
| done | output | 1 | One-cycle end-of-operation strobe |

## Verification
An address register that jumps or fails to roll over shows on mem_addr in the very access cycle where the step goes wrong. A wrong byte count or a wrong store-shift stage shows as an extra, missing or mis-valued byte access within one cycle. A fault in the assembly register or the extension selection stays hidden until res_valid rises n+2 cycles after acceptance, and it then shows as a wrong res_data. A broken state sequence shows up as one of three things: a result or done strobe that is early, late or repeated; a lost hold under back-pressure; or req_ready overlapping an access.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int CNT_W      = $clog2(WORD_BYTES + 1);

  typedef enum logic [2:0] {
    OP_LB  = 3'd0,
    OP_LBU = 3'd1,
    OP_LH  = 3'd2,
    OP_LHU = 3'd3,
    OP_LW  = 3'd4,
    OP_SB  = 3'd5,
    OP_SH  = 3'd6,
    OP_SW  = 3'd7
  } lsu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_COLLECT = 2'd2,
    ST_RESP    = 2'd3
  } lsu_state_e;

  function automatic logic op_is_store(lsu_op_e op);
    return (op == OP_SB) || (op == OP_SH) || (op == OP_SW);
  endfunction

  function automatic logic [CNT_W-1:0] op_bytes(lsu_op_e op);
    case (op)
      OP_LB, OP_LBU, OP_SB: return CNT_W'(1);
      OP_LH, OP_LHU, OP_SH: return CNT_W'(2);
      default:              return CNT_W'(WORD_BYTES);
    endcase
  endfunction

endpackage

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  lsu_op_e            op,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  offset,
  output logic [ADDR_W-1:0]  ea,
  output logic [CNT_W-1:0]   nbytes,
  output logic               is_store
);
  // Only the low address bits of base and extended offset can reach a
  // wrapped address, so the sum is taken at address width directly.
  assign ea       = base + offset;
  assign nbytes   = op_bytes(op);
  assign is_store = op_is_store(op);
endmodule

// File: rtl/lsu_byte_seq.sv
module lsu_byte_seq
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  ea,
  input  logic [CNT_W-1:0]   nbytes,
  input  logic               is_store,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               res_ready,
  output logic               idle,
  output logic               mem_en,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  output logic               capture,
  output logic               res_valid,
  output logic               done
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  lsu_state_e          state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [CNT_W-1:0]    idx_q;
  logic [CNT_W-1:0]    n_q;
  logic                st_q;
  logic [WORD_W-1:0]   sh_q;
  logic [WORD_W-1:0]   sh_init;
  logic                rd_pend_q;
  logic                done_q;
  logic                last;

  // Left-justify the covered low bytes so the most significant goes first.
  always_comb begin
    case (nbytes)
      CNT_W'(1): sh_init = {wdata[7:0],  {(WORD_W-8){1'b0}}};
      CNT_W'(2): sh_init = {wdata[15:0], {(WORD_W-16){1'b0}}};
      default:   sh_init = wdata;
    endcase
  end

  assign last = (idx_q + CNT_ONE) == n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      idx_q     <= '0;
      n_q       <= '0;
      st_q      <= 1'b0;
      sh_q      <= '0;
      rd_pend_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      rd_pend_q <= (state_q == ST_ACCESS) && !st_q;
      done_q    <= ((state_q == ST_ACCESS) && last && st_q) ||
                   ((state_q == ST_RESP) && res_ready);
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q  <= ea;
            idx_q   <= '0;
            n_q     <= nbytes;
            st_q    <= is_store;
            sh_q    <= sh_init;
            state_q <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          addr_q <= addr_q + ADDR_ONE;
          idx_q  <= idx_q + CNT_ONE;
          sh_q   <= {sh_q[WORD_W-9:0], 8'h00};
          if (last) state_q <= st_q ? ST_IDLE : ST_COLLECT;
        end
        ST_COLLECT: state_q <= ST_RESP;
        ST_RESP:    if (res_ready) state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign mem_en    = (state_q == ST_ACCESS);
  assign mem_we    = mem_en && st_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = sh_q[WORD_W-1 -: 8];
  assign capture   = rd_pend_q;
  assign res_valid = (state_q == ST_RESP);
  assign done      = done_q;
endmodule

// File: rtl/lsu_load_pack.sv
module lsu_load_pack
  import lsu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               capture,
  input  logic [7:0]         rdata,
  input  lsu_op_e            op,
  input  logic               dest_zero,
  output logic [WORD_W-1:0]  data
);
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] ext;

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear)   acc_q <= '0;
    else if (capture) acc_q <= {acc_q[WORD_W-9:0], rdata};
  end

  always_comb begin
    case (op)
      OP_LB:   ext = {{(WORD_W-8){acc_q[7]}},   acc_q[7:0]};
      OP_LBU:  ext = {{(WORD_W-8){1'b0}},       acc_q[7:0]};
      OP_LH:   ext = {{(WORD_W-16){acc_q[15]}}, acc_q[15:0]};
      OP_LHU:  ext = {{(WORD_W-16){1'b0}},      acc_q[15:0]};
      default: ext = acc_q;
    endcase
  end

  assign data = dest_zero ? '0 : ext;
endmodule

// File: rtl/lsu_wrap_unit.sv
module lsu_wrap_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int RIDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic [ADDR_W-1:0]  req_base,
  input  logic [ADDR_W-1:0]  req_offset,
  input  logic [WORD_W-1:0]  req_wdata,
  input  logic [RIDX_W-1:0]  req_rd,
  output logic               mem_en,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [WORD_W-1:0]  res_data,
  output logic [RIDX_W-1:0]  res_rd,
  output logic               done
);
  lsu_op_e            op_in;
  lsu_op_e            op_q;
  logic [RIDX_W-1:0]  rd_q;
  logic               start;
  logic               idle;
  logic               capture;
  logic [ADDR_W-1:0]  ea;
  logic [CNT_W-1:0]   nbytes;
  logic               is_store;

  assign op_in     = lsu_op_e'(req_op);
  assign req_ready = idle;
  assign start     = req_valid && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= OP_LB;
      rd_q <= '0;
    end else if (start) begin
      op_q <= op_in;
      rd_q <= req_rd;
    end
  end

  lsu_ea_calc #(.ADDR_W(ADDR_W)) u_ea (
    .op       (op_in),
    .base     (req_base),
    .offset   (req_offset),
    .ea       (ea),
    .nbytes   (nbytes),
    .is_store (is_store)
  );

  lsu_byte_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ea        (ea),
    .nbytes    (nbytes),
    .is_store  (is_store),
    .wdata     (req_wdata),
    .res_ready (res_ready),
    .idle      (idle),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .capture   (capture),
    .res_valid (res_valid),
    .done      (done)
  );

  lsu_load_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .capture   (capture),
    .rdata     (mem_rdata),
    .op        (op_q),
    .dest_zero (rd_q == '0),
    .data      (res_data)
  );

  assign res_rd = rd_q;
endmodule

// File: rtl/lsu_wrap_unit_chk.sv
module lsu_wrap_unit_chk #(
  parameter int ADDR_W = 12,
  parameter int RIDX_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               mem_en,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               res_valid,
  input logic               res_ready,
  input logic [31:0]        res_data,
  input logic [RIDX_W-1:0]  res_rd,
  input logic               done
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  assert_ready_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && mem_en));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> (!mem_en || mem_addr == $past(mem_addr) + STEP));

  assert_quiet_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_en);

  assert_zero_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_rd == '0) |-> res_data == 32'h0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_rd)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind lsu_wrap_unit lsu_wrap_unit_chk #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_en    (mem_en),
  .mem_addr  (mem_addr),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_rd    (res_rd),
  .done      (done)
);

// File: tb/lsu_wrap_unit_test.sv
module lsu_wrap_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [11:0] req_base = 12'd0;
  logic [11:0] req_offset = 12'd0;
  logic [31:0] req_wdata = 32'd0;
  logic [4:0]  req_rd = 5'd0;
  logic        mem_en, mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'd0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_data;
  logic [4:0]  res_rd;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0]  bmem    [4096];
  logic [7:0]  ref_mem [4096];
  logic [20:0] exp_q   [$];

  always #4 clk = ~clk;

  lsu_wrap_unit uut (.*);

  // Bench-side memory: writes land at the edge, reads return next cycle.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every access cycle is compared against the model's expected sequence.
  always @(negedge clk) begin
    if (rst_n && mem_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected access", {19'd0, mem_we, mem_addr}, 32'h0);
      end else begin
        logic [20:0] e;
        e = exp_q.pop_front();
        chk(mem_addr == e[19:8], "R2 access address", {20'd0, mem_addr}, {20'd0, e[19:8]});
        chk(mem_we == e[20], "R4 write enable", {31'd0, mem_we}, {31'd0, e[20]});
        if (e[20]) chk(mem_wdata == e[7:0], "R4 write byte", {24'd0, mem_wdata}, {24'd0, e[7:0]});
      end
    end
  end

  task automatic run_op(input logic [2:0] op, input logic [11:0] base, input logic [11:0] off,
                        input logic [31:0] wd, input logic [4:0] rd, input int hold, input string tag);
    int n;
    bit st;
    logic [11:0] ea;
    logic [31:0] acc, expv;
    n  = (op == 3'd0 || op == 3'd1 || op == 3'd5) ? 1 :
         (op == 3'd2 || op == 3'd3 || op == 3'd6) ? 2 : 4;
    st = (op >= 3'd5);
    ea = base + off;
    acc = 32'd0;
    @(negedge clk);
    chk(req_ready, {tag, " R3 ready before request"}, {31'd0, req_ready}, 32'd1);
    for (int k = 0; k < n; k++) begin
      logic [11:0] a;
      logic [7:0]  b;
      a = ea + 12'(k);
      b = 8'((wd >> (8 * (n - 1 - k))) & 32'hFF);
      if (st) begin
        exp_q.push_back({1'b1, a, b});
        ref_mem[a] = b;
      end else begin
        exp_q.push_back({1'b0, a, 8'h00});
        acc = (acc << 8) | {24'd0, ref_mem[a]};
      end
    end
    case (op)
      3'd0:    expv = {{24{acc[7]}}, acc[7:0]};
      3'd1:    expv = {24'd0, acc[7:0]};
      3'd2:    expv = {{16{acc[15]}}, acc[15:0]};
      3'd3:    expv = {16'd0, acc[15:0]};
      default: expv = acc;
    endcase
    if (rd == 5'd0) expv = 32'd0;
    req_valid = 1'b1; req_op = op; req_base = base; req_offset = off;
    req_wdata = wd; req_rd = rd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_en && mem_addr == ea, {tag, " R1 first access address"}, {20'd0, mem_addr}, {20'd0, ea});
    if (st) begin
      repeat (n) @(negedge clk);
      chk(done, {tag, " R11 store done strobe"}, {31'd0, done}, 32'd1);
      chk(exp_q.size() == 0, {tag, " R4 access count"}, 32'(exp_q.size()), 32'd0);
      @(negedge clk);
      chk(!done && req_ready, {tag, " R11 done single cycle"}, {31'd0, done}, 32'd0);
    end else begin
      repeat (n) @(negedge clk);
      chk(!res_valid, {tag, " R5 not early"}, {31'd0, res_valid}, 32'd0);
      @(negedge clk);
      chk(res_valid, {tag, " R5 result valid"}, {31'd0, res_valid}, 32'd1);
      chk(res_data == expv, {tag, " R6 R7 R8 R9 load value"}, res_data, expv);
      chk(res_rd == rd, {tag, " R5 destination"}, {27'd0, res_rd}, {27'd0, rd});
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(res_valid && res_data == expv && !done, {tag, " R10 hold"}, res_data, expv);
      end
      res_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      res_ready = 1'b0;
      chk(done && !res_valid, {tag, " R11 load done strobe"}, {31'd0, done}, 32'd1);
      chk(exp_q.size() == 0, {tag, " R2 access count"}, 32'(exp_q.size()), 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      bmem[i]    = 8'((i * 37 + 5) & 255);
      ref_mem[i] = 8'((i * 37 + 5) & 255);
    end
    bmem[12'h040] = 8'h9C; ref_mem[12'h040] = 8'h9C;
    bmem[12'h103] = 8'hF1; ref_mem[12'h103] = 8'hF1;
    bmem[12'h104] = 8'h22; ref_mem[12'h104] = 8'h22;
    bmem[12'hFFF] = 8'h85; ref_mem[12'hFFF] = 8'h85;
    bmem[12'h000] = 8'h3A; ref_mem[12'h000] = 8'h3A;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_en && !res_valid && !done, "R3 reset state", {28'd0, req_ready, mem_en, res_valid, done}, 32'h8);

    run_op(3'd4, 12'h100, 12'h000, 32'h0, 5'd3, 0, "aligned word R8");
    run_op(3'd0, 12'h030, 12'h010, 32'h0, 5'd4, 0, "signed byte R6");
    run_op(3'd1, 12'h040, 12'h000, 32'h0, 5'd5, 0, "unsigned byte R6");
    run_op(3'd2, 12'h100, 12'h003, 32'h0, 5'd6, 0, "split halfword signed R7");
    run_op(3'd3, 12'h103, 12'h000, 32'h0, 5'd7, 0, "split halfword unsigned R7");
    run_op(3'd2, 12'hFF0, 12'h00F, 32'h0, 5'd8, 0, "wrapped halfword R7");
    run_op(3'd4, 12'hFFE, 12'h000, 32'h0, 5'd9, 0, "wrapped word R8");
    run_op(3'd4, 12'h010, 12'hFF0, 32'h0, 5'd10, 0, "negative offset R1");
    run_op(3'd5, 12'h200, 12'h001, 32'hDEADBE5A, 5'd0, 0, "byte store R4");
    run_op(3'd4, 12'h200, 12'h000, 32'h0, 5'd11, 0, "byte store readback R4");
    run_op(3'd6, 12'hFFF, 12'h000, 32'h1234C0DE, 5'd0, 0, "wrapped halfword store R4");
    run_op(3'd4, 12'hFFE, 12'h000, 32'h0, 5'd12, 0, "halfword store readback R7");
    run_op(3'd7, 12'h301, 12'h000, 32'hA1B2C3D4, 5'd0, 0, "unaligned word store R8");
    run_op(3'd4, 12'h300, 12'h000, 32'h0, 5'd13, 0, "store readback low R8");
    run_op(3'd4, 12'h304, 12'h000, 32'h0, 5'd14, 0, "store readback high R8");
    run_op(3'd4, 12'h300, 12'h000, 32'h0, 5'd0, 0, "zero destination R9");
    run_op(3'd1, 12'hFFF, 12'h000, 32'h0, 5'd15, 5, "back-pressure R10");
    run_op(3'd2, 12'h0FF, 12'h004, 32'h0, 5'd16, 3, "back-pressure halfword R10");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule